// File: doc/BRIEF.md
# Accumulator Memory-Reference Sequencer

This block is the multi-cycle control and datapath of a small 16-bit computer built around one accumulator. It fetches an instruction word from a word memory and decodes a 3-bit operation code and an indirect flag from it. It then runs one of seven memory-reference operations: bitwise AND, add with carry, load, store, unconditional jump, subroutine call that stores a return address, and increment-and-skip-if-zero. A one-hot step register steps through timing phases T0, T1, T2 and onward. A decoded term made of an opcode line ANDed with a step line returns it to T0 when an instruction is finished.

The memory address always comes from the internal address register. Memory reads are combinational from that address, and writes take effect on the clock edge in the step that asserts the write enable. The memory port has a fixed timing and no back-pressure: it has no valid/ready pair, and the memory must give read data in the same cycle and accept a write in any cycle. Opcode 7 is not run here. It is passed to an outside unit through a one-cycle strobe, and the sequencer waits at T3 until that unit returns a done pulse. A halt input freezes the whole block. A synchronous reset puts it back to its start state.

Top module: `memref_sequencer`

## Requirements
- R1: While reset is high at a clock edge, the next state is: PC = START_ADDR, accumulator = 0, E = 0, step output = T0 (bit 0 set). Reset takes effect even when halt is high.
- R2: Fetch runs in three steps. T0 copies PC into the address register. T1 loads the instruction register from memory and increments PC, wrapping modulo 2^ADDR_W. T2 copies the low ADDR_W bits of the instruction into the address register. Instruction bit 15 is the indirect flag, and bits 14:12 are the opcode (0 AND, 1 ADD, 2 LDA, 3 STA, 4 BUN, 5 BSA, 6 ISZ, 7 hand-off). Bits between the opcode and the address field are ignored.
- R3: At T3, if bit 15 is set and the opcode is not 7, the address register is replaced by the low ADDR_W bits of the memory word it points to. This takes the same cycle count as the direct case.
- R4: AND and LDA read the operand at T4 and update the accumulator at T5, with AC & M for AND and M for LDA. E is unchanged, and the step returns to T0 after T5.
- R5: ADD sets the accumulator to the low 16 bits of AC + M at T5, and E to the carry out of that sum.
- R6: STA writes the accumulator to the effective address at T4, which is the only write of the instruction. The step returns to T0 after T4.
- R7: BUN loads PC with the effective address at T4 and returns to T0.
- R8: BSA writes PC, zero-extended, to the effective address at T4. It then loads PC with the effective address plus one at T5.
- R9: ISZ reads the word at T4 and increments it at T5. At T6 it writes the incremented word back, and if that word is zero it increments PC once more.
- R10: Opcode 7 raises a strobe for exactly one cycle at T3. The strobe is reg_strobe when bit 15 is clear and io_strobe when it is set. The step then holds at T3 until ext_done is high at an edge, and T0 follows. ext_done at any other time has no effect.
- R11: While halt is high, no register changes, mem_we is low and no strobe is raised.
- R12: The step output is always one-hot, with bit k meaning Tk. The write enable is only ever high in T4 or T6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Freeze all state while high |
| ext_done | input | 1 | Hand-off unit finished; releases T3 hold |
| mem_addr | output | ADDR_W | Memory address, always the address register |
| mem_rdata | input | DATA_W | Memory read data for mem_addr, same cycle |
| mem_we | output | 1 | Memory write enable, write at clock edge |
| mem_wdata | output | DATA_W | Memory write data |
| reg_strobe | output | 1 | Opcode 7 hand-off, bit 15 clear |
| io_strobe | output | 1 | Opcode 7 hand-off, bit 15 set |
| instr | output | DATA_W | Instruction register, for the hand-off unit |
| t_step | output | 8 | One-hot timing step |
| pc_q | output | ADDR_W | Program counter |
| ac_q | output | DATA_W | Accumulator |
| e_q | output | 1 | Carry flip-flop E |

## Verification
The bench builds the block with DATA_W = 16, ADDR_W = 8 and START_ADDR = 16. A 256-word memory then holds the whole program, the pointer words and the return address. The program places an instruction at address 255, so PC wraps to 0 during fetch. Unused instruction bits 11:8 are set in one indirect load, to show that only the low eight bits form the address. The ISZ skip, the BSA return through an indirect jump, a stray done pulse, halts during execution and both hand-off strobes, one released late and one released in its own strobe cycle, all fall within a few hundred cycles.

// File: rtl/memref_pkg.sv
package memref_pkg;
  localparam int OPC_W = 3;
  localparam int STEP_N = 8;

  typedef enum logic [OPC_W-1:0] {
    OP_AND = 3'd0,
    OP_ADD = 3'd1,
    OP_LDA = 3'd2,
    OP_STA = 3'd3,
    OP_BUN = 3'd4,
    OP_BSA = 3'd5,
    OP_ISZ = 3'd6,
    OP_EXT = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    ALU_AND  = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_PASS = 2'd2,
    ALU_INC  = 2'd3
  } alu_op_e;
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int STEPS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clear,
  input  logic             hold,
  output logic [STEPS-1:0] step
);
  localparam logic [STEPS-1:0] FIRST = STEPS'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= FIRST;
    end else if (run) begin
      if (clear) begin
        step <= FIRST;
      end else if (!hold) begin
        step <= {step[STEPS-2:0], step[STEPS-1]};
      end
    end
  end
endmodule

// File: rtl/op_decoder.sv
module op_decoder #(
  parameter int W = 3
) (
  input  logic [W-1:0]      code,
  output logic [(1<<W)-1:0] lines
);
  localparam int N = 1 << W;

  for (genvar k = 0; k < N; k++) begin : g_line
    assign lines[k] = (code == W'(k));
  end
endmodule

// File: rtl/memref_alu.sv
module memref_alu
  import memref_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   y,
  output logic            carry
);
  logic [DW:0] wide;

  always_comb begin
    wide = '0;
    unique case (op)
      ALU_AND:  wide = {1'b0, a & b};
      ALU_ADD:  wide = {1'b0, a} + {1'b0, b};
      ALU_PASS: wide = {1'b0, b};
      ALU_INC:  wide = {1'b0, b} + (DW+1)'(1);
      default:  wide = '0;
    endcase
    y     = wide[DW-1:0];
    carry = wide[DW];
  end
endmodule

// File: rtl/memref_sequencer.sv
module memref_sequencer
  import memref_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 12,
  parameter int START_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt,
  input  logic              ext_done,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              reg_strobe,
  output logic              io_strobe,
  output logic [DATA_W-1:0] instr,
  output logic [STEP_N-1:0] t_step,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] ac_q,
  output logic              e_q
);
  localparam int IND_BIT = DATA_W - 1;
  localparam int OPC_LSB = DATA_W - 1 - OPC_W;
  localparam int OP_N    = 1 << OPC_W;
  localparam int PAD_W   = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc, ar;
  logic [DATA_W-1:0] ir, ac, dr;
  logic              e, wait_q;
  logic [OP_N-1:0]   d;
  logic [STEP_N-1:0] t;
  logic              run, ind, clr_term, hold_term, strobe;
  logic              wr_term, fetch_opnd;
  alu_op_e           alu_sel;
  logic [DATA_W-1:0] alu_y;
  logic              alu_c;

  assign run = !halt;
  assign ind = ir[IND_BIT];

  op_decoder #(.W(OPC_W)) u_dec (
    .code  (ir[OPC_LSB +: OPC_W]),
    .lines (d)
  );

  // Decoded end-of-instruction terms: opcode line AND step line.
  assign clr_term = (t[3] & d[OP_EXT] & ext_done)
                  | (t[4] & (d[OP_STA] | d[OP_BUN]))
                  | (t[5] & (d[OP_AND] | d[OP_ADD] | d[OP_LDA] | d[OP_BSA]))
                  | (t[6] & d[OP_ISZ]);
  assign hold_term = t[3] & d[OP_EXT];

  seq_timer #(.STEPS(STEP_N)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .clear (clr_term),
    .hold  (hold_term),
    .step  (t)
  );

  always_comb begin
    if (d[OP_AND])      alu_sel = ALU_AND;
    else if (d[OP_ADD]) alu_sel = ALU_ADD;
    else if (d[OP_LDA]) alu_sel = ALU_PASS;
    else                alu_sel = ALU_INC;
  end

  memref_alu #(.DW(DATA_W)) u_alu (
    .op    (alu_sel),
    .a     (ac),
    .b     (dr),
    .y     (alu_y),
    .carry (alu_c)
  );

  assign fetch_opnd = d[OP_AND] | d[OP_ADD] | d[OP_LDA] | d[OP_ISZ];
  assign wr_term    = (t[4] & (d[OP_STA] | d[OP_BSA])) | (t[6] & d[OP_ISZ]);
  assign strobe     = run & t[3] & d[OP_EXT] & !wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= ADDR_W'(START_ADDR);
      ar     <= '0;
      ir     <= '0;
      ac     <= '0;
      dr     <= '0;
      e      <= 1'b0;
      wait_q <= 1'b0;
    end else if (run) begin
      if (t[0]) ar <= pc;
      if (t[1]) begin
        ir <= mem_rdata;
        pc <= pc + ADDR_W'(1);
      end
      if (t[2]) ar <= ir[ADDR_W-1:0];
      if (t[3] & !d[OP_EXT] & ind) ar <= mem_rdata[ADDR_W-1:0];
      if (t[3] & d[OP_EXT]) wait_q <= !ext_done;
      if (t[4] & fetch_opnd) dr <= mem_rdata;
      if (t[4] & d[OP_BUN]) pc <= ar;
      if (t[4] & d[OP_BSA]) ar <= ar + ADDR_W'(1);
      if (t[5] & d[OP_BSA]) pc <= ar;
      if (t[5] & (d[OP_AND] | d[OP_ADD] | d[OP_LDA])) ac <= alu_y;
      if (t[5] & d[OP_ADD]) e <= alu_c;
      if (t[5] & d[OP_ISZ]) dr <= alu_y;
      if (t[6] & d[OP_ISZ] & (dr == '0)) pc <= pc + ADDR_W'(1);
    end
  end

  assign mem_addr   = ar;
  assign mem_we     = run & wr_term;
  assign mem_wdata  = d[OP_BSA] ? {{PAD_W{1'b0}}, pc} : (d[OP_ISZ] ? dr : ac);
  assign reg_strobe = strobe & !ind;
  assign io_strobe  = strobe & ind;
  assign instr      = ir;
  assign t_step     = t;
  assign pc_q       = pc;
  assign ac_q       = ac;
  assign e_q        = e;
endmodule

// File: rtl/memref_sequencer_chk.sv
module memref_sequencer_chk
  import memref_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 12,
  parameter int START_ADDR = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              halt,
  input logic              mem_we,
  input logic              reg_strobe,
  input logic              io_strobe,
  input logic [STEP_N-1:0] t_step,
  input logic [ADDR_W-1:0] pc_q,
  input logic [DATA_W-1:0] ac_q,
  input logic              e_q
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (t_step == STEP_N'(1) && pc_q == ADDR_W'(START_ADDR) && ac_q == '0 && !e_q));

  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (t_step[1] && !halt) |=> (pc_q == ADDR_W'($past(pc_q) + ADDR_W'(1))));

  a_r10_strobe_at_t3: assert property (@(posedge clk) disable iff (rst)
    (reg_strobe || io_strobe) |-> t_step[3]);

  a_r10_strobe_single: assert property (@(posedge clk) disable iff (rst)
    (reg_strobe || io_strobe) |=> !(reg_strobe || io_strobe));

  a_r11_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    halt |-> (!mem_we && !reg_strobe && !io_strobe));

  a_r11_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    halt |=> ($stable(pc_q) && $stable(ac_q) && $stable(e_q) && $stable(t_step)));

  a_r12_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(t_step) == 1);

  a_r12_write_steps: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (t_step[4] || t_step[6]));
endmodule

bind memref_sequencer memref_sequencer_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .START_ADDR(START_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .halt(halt), .mem_we(mem_we),
  .reg_strobe(reg_strobe), .io_strobe(io_strobe), .t_step(t_step),
  .pc_q(pc_q), .ac_q(ac_q), .e_q(e_q)
);

// File: tb/memref_sequencer_tb.sv
`timescale 1ns/1ps
module memref_sequencer_tb;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int START = 16;
  localparam int MW = 1 << AW;
  localparam int AMASK = MW - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt = 1'b0;
  logic ext_done = 1'b0;
  logic [AW-1:0] mem_addr, pc_q;
  logic [DW-1:0] mem_rdata, mem_wdata, instr, ac_q;
  logic mem_we, reg_strobe, io_strobe, e_q;
  logic [7:0] t_step;

  always #2 clk = ~clk;

  memref_sequencer #(.DATA_W(DW), .ADDR_W(AW), .START_ADDR(START)) u_dut (
    .clk(clk), .rst(rst), .halt(halt), .ext_done(ext_done),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .reg_strobe(reg_strobe), .io_strobe(io_strobe),
    .instr(instr), .t_step(t_step), .pc_q(pc_q), .ac_q(ac_q), .e_q(e_q)
  );

  logic [DW-1:0] mem [MW];
  logic [DW-1:0] mm  [MW];
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  int checks = 0, fails = 0, cyc = 0;
  int m_pc = START, m_ar = 0, m_ir = 0, m_ac = 0, m_e = 0, m_dr = 0;
  int m_step = 0, m_wait = 0;
  bit armed = 0, done_flag = 0;
  int n_rr = 0, n_io = 0, n_hand = 0, pend = 0, cnt = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic logic [15:0] ins(bit i, int op, int a);
    return {i, 3'(op), 4'h0, 8'(a)};
  endfunction

  function automatic string tag_of(int step, int ir, bit h);
    int op;
    op = (ir >> 12) & 7;
    if (h) return "R11";
    if (step < 3) return "R2";
    if (step == 3 && op != 7 && ir[15]) return "R3";
    case (op)
      0, 2: return "R4";
      1: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Behavioural reference model, one register transfer per step.
  always @(posedge clk) begin
    int op, s;
    if (rst) begin
      m_pc = START; m_ar = 0; m_ir = 0; m_ac = 0; m_e = 0; m_dr = 0;
      m_step = 0; m_wait = 0; armed = 1;
    end else if (armed && !halt) begin
      op = (m_ir >> 12) & 7;
      case (m_step)
        0: begin m_ar = m_pc; m_step = 1; end
        1: begin m_ir = int'(mm[m_ar]); m_pc = (m_pc + 1) & AMASK; m_step = 2; end
        2: begin m_ar = m_ir & AMASK; m_step = 3; end
        3: begin
          if (op == 7) begin
            if (ext_done) begin m_step = 0; m_wait = 0; end
            else m_wait = 1;
          end else begin
            if (m_ir[15]) m_ar = int'(mm[m_ar]) & AMASK;
            m_step = 4;
          end
        end
        4: begin
          case (op)
            3: begin mm[m_ar] = 16'(m_ac); m_step = 0; end
            4: begin m_pc = m_ar; m_step = 0; end
            5: begin mm[m_ar] = 16'(m_pc); m_ar = (m_ar + 1) & AMASK; m_step = 5; end
            default: begin m_dr = int'(mm[m_ar]); m_step = 5; end
          endcase
        end
        5: begin
          m_step = 0;
          case (op)
            0: m_ac = m_ac & m_dr;
            1: begin s = m_ac + m_dr; m_ac = s & 16'hFFFF; m_e = (s >> 16) & 1; end
            2: m_ac = m_dr;
            5: m_pc = m_ar;
            6: begin m_dr = (m_dr + 1) & 16'hFFFF; m_step = 6; end
            default: ;
          endcase
        end
        default: begin
          mm[m_ar] = 16'(m_dr);
          if (m_dr == 0) m_pc = (m_pc + 1) & AMASK;
          m_step = 0;
        end
      endcase
    end
  end

  // Per-cycle comparison, then input drive for the next edge.
  always @(negedge clk) begin
    int op;
    bit exp_we, exp_st;
    logic [15:0] exp_wd;
    string tg;
    if (armed) begin
      op = (m_ir >> 12) & 7;
      tg = tag_of(m_step, m_ir, halt);
      exp_we = !halt && ((m_step == 4 && (op == 3 || op == 5)) || (m_step == 6 && op == 6));
      exp_wd = (op == 5) ? 16'(m_pc) : ((op == 6) ? 16'(m_dr) : 16'(m_ac));
      exp_st = !halt && m_step == 3 && op == 7 && m_wait == 0;
      chk("R12 step", 32'(t_step), 32'(1 << m_step));
      chk({tg, " pc"}, 32'(pc_q), 32'(m_pc));
      chk({tg, " ac"}, 32'(ac_q), 32'(m_ac));
      chk({tg, " e"}, 32'(e_q), 32'(m_e));
      chk({tg, " we"}, 32'(mem_we), 32'(exp_we));
      if (exp_we) begin
        chk({tg, " waddr"}, 32'(mem_addr), 32'(m_ar));
        chk({tg, " wdata"}, 32'(mem_wdata), 32'(exp_wd));
      end
      chk("R10 reg_strobe", 32'(reg_strobe), 32'(exp_st && !m_ir[15]));
      chk("R10 io_strobe", 32'(io_strobe), 32'(exp_st && m_ir[15]));
    end
    if (!rst) cyc++;
    if (reg_strobe) n_rr++;
    if (io_strobe) n_io++;
    halt = (cyc >= 40 && cyc < 45) || (cyc >= 150 && cyc < 153);
    if (reg_strobe || io_strobe) begin
      pend = 1; cnt = (n_hand == 0) ? 3 : 0; n_hand++;
    end
    if (pend && cnt == 0 && !halt) begin
      ext_done = 1'b1; pend = 0;
    end else begin
      ext_done = (cyc == 12 && !halt);  // stray pulse, R10 says no effect
      if (pend && cnt > 0) cnt--;
    end
  end

  initial begin
    for (int k = 0; k < MW; k++) begin mem[k] = '0; mm[k] = '0; end
    mem[16] = ins(0, 2, 100);
    mem[17] = ins(0, 1, 101);
    mem[18] = ins(0, 0, 102);
    mem[19] = ins(0, 3, 103);
    mem[20] = ins(1, 2, 104) | 16'h0F00;
    mem[21] = ins(0, 6, 106);
    mem[22] = ins(0, 6, 106);
    mem[23] = ins(0, 3, 107);
    mem[24] = ins(0, 5, 120);
    mem[121] = ins(0, 7, 0) | 16'h0800;
    mem[122] = ins(1, 7, 0) | 16'h0400;
    mem[123] = ins(1, 4, 120);
    mem[25] = ins(0, 1, 108);
    mem[26] = ins(0, 4, 255);
    mem[255] = ins(0, 4, 27);
    mem[27] = ins(0, 4, 27);
    mem[100] = 16'h8001;
    mem[101] = 16'h8000;
    mem[102] = 16'h00FF;
    mem[104] = 16'd105;
    mem[105] = 16'h1234;
    mem[106] = 16'hFFFE;
    mem[108] = 16'h0001;
    for (int k = 0; k < MW; k++) mm[k] = mem[k];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wait (cyc == 420);
    @(negedge clk);
    chk("R6 store result", 32'(mem[103]), 32'h1);
    chk("R9 isz wrote zero", 32'(mem[106]), 32'h0);
    chk("R9 skipped store", 32'(mem[107]), 32'h0);
    chk("R8 return address", 32'(mem[120]), 32'd25);
    chk("R5 final ac", 32'(ac_q), 32'h1235);
    chk("R5 final e", 32'(e_q), 32'h0);
    chk("R7 loop target", 32'(pc_q == 8'd27 || pc_q == 8'd28), 32'h1);
    chk("R10 one reg strobe", 32'(n_rr), 32'd1);
    chk("R10 one io strobe", 32'(n_io), 32'd1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 pc after reset", 32'(pc_q), 32'(START));
    chk("R1 ac after reset", 32'(ac_q), 32'h0);
    chk("R1 step after reset", 32'(t_step), 32'h1);
    finish_run();
  end

  initial begin
    #(4 * 5000);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end
endmodule